// File: doc/BRIEF.md
# Lockstep Multiply and Bit-Manipulation Execute Extension

This unit extends the execute stage of a 32-bit RISC core with extra arithmetic instructions. In the first cycle of each instruction's execution the core presents two register operands and two fields taken from the instruction word: a 6-bit function code and a 5-bit modifier. An issue strobe marks the cycle as carrying a real instruction. The unit decodes the function code itself and drives the 32-bit result bus before the end of the execute cycle. The core then writes that result into its own register file during writeback.

Bit operations complete in the issue cycle. Multiply and multiply-accumulate take `MUL_LAT` cycles, four by default. For those cycles the unit raises a stall request. The core holds its pipeline, keeps the strobe high and delivers the result when the request drops. The unit runs in lockstep with the instruction stream. It therefore needs no hazard tracking and no transfer handshake.

A 64-bit accumulator inside the unit collects multiply-accumulate results. Two read instructions return its two halves. A function code that does not decode raises a one-cycle illegal-operation flag and returns zero. A synchronous reset clears the accumulator and abandons any multiply in flight.

Top module: `cust_alu_ext`

## Requirements
- R1: Function codes are: 0x10 multiply low, 0x11 multiply high signed, 0x12 multiply high unsigned, 0x13 multiply-accumulate, 0x14 read accumulator bits 31:0, 0x15 read accumulator bits 63:32, 0x20 count leading zeros, 0x21 bit reverse, 0x22 population count. The single-cycle codes (0x14, 0x15, 0x20 to 0x22) return their result in the issue cycle and never raise the stall request.
- R2: Count leading zeros returns the number of zero bits above the highest set bit of operand A, and returns 32 when A is zero.
- R3: Bit reverse returns operand A with bit i moved to bit 31-i.
- R4: Population count returns the number of set bits in operand A.
- R5: A multiply or multiply-accumulate raises the stall request for exactly MUL_LAT-1 consecutive cycles, starting in the issue cycle. The request is low in the cycle that carries the result.
- R6: Multiply low returns bits 31:0 of A*B. Multiply high signed returns bits 63:32 of the two's-complement product. Multiply high unsigned returns bits 63:32 of the unsigned product.
- R7: Multiply-accumulate adds A*B to the 64-bit accumulator and returns bits 31:0 of the new sum. The product is signed when modifier bit 0 is 0 and unsigned when it is 1. The two read codes return the accumulator halves without changing it.
- R8: An undefined function code returns zero, raises the illegal flag in its issue cycle, never stalls and leaves the accumulator unchanged.
- R9: With the issue strobe low, the result bus, stall request and illegal flag are all zero. Operand changes during a multiply's stall cycles do not affect its result.
- R10: A synchronous reset clears the accumulator and drops any multiply in progress, so the stall request is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | Marks a valid instruction in the execute stage |
| func_fld | input | 6 | Function subfield of the instruction word |
| aux_fld | input | 5 | Modifier subfield (bit 0 selects an unsigned multiply-accumulate) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| dst_res | output | 32 | Result bus sampled by the host at writeback |
| stall_req | output | 1 | Holds the host pipeline while a multiply completes |
| illegal_op | output | 1 | One-cycle flag for an undefined function code |

## Verification
If the cycle counter is wrong, the stall run has the wrong length, and this shows within the multiply that caused it. Because the core is frozen, a run that is too short also places a stale or partly piped product on the result bus in that multiply's last cycle. A corrupted accumulator stays hidden until the next multiply-accumulate or accumulator read, so the stimulus interleaves reads with accumulations. Operands that are captured wrongly appear only in that operation's own result, and changing the operands during stalls exposes them.

// File: rtl/cax_pkg.sv
package cax_pkg;

   localparam int CAX_FUNC_W = 6;

   localparam logic [CAX_FUNC_W-1:0] FC_MULLO = 6'h10;
   localparam logic [CAX_FUNC_W-1:0] FC_MULHS = 6'h11;
   localparam logic [CAX_FUNC_W-1:0] FC_MULHU = 6'h12;
   localparam logic [CAX_FUNC_W-1:0] FC_MAC   = 6'h13;
   localparam logic [CAX_FUNC_W-1:0] FC_ACCLO = 6'h14;
   localparam logic [CAX_FUNC_W-1:0] FC_ACCHI = 6'h15;
   localparam logic [CAX_FUNC_W-1:0] FC_CLZ   = 6'h20;
   localparam logic [CAX_FUNC_W-1:0] FC_BREV  = 6'h21;
   localparam logic [CAX_FUNC_W-1:0] FC_POPC  = 6'h22;

   typedef enum logic [3:0] {
      K_NONE,
      K_MULLO,
      K_MULHS,
      K_MULHU,
      K_MAC,
      K_ACCLO,
      K_ACCHI,
      K_CLZ,
      K_BREV,
      K_POPC
   } cax_kind_e;

   typedef struct packed {
      cax_kind_e kind;
      logic      multi;
      logic      illegal;
      logic      sgn;
   } cax_dec_t;

endpackage

// File: rtl/cax_decode.sv
module cax_decode
   import cax_pkg::*;
#(
   parameter int AUX_W = 5
) (
   input  logic [CAX_FUNC_W-1:0] func,
   input  logic [AUX_W-1:0]      aux,
   output cax_dec_t              dec
);

   if (AUX_W < 1) begin : g_bad_aux
      $error("cax_decode: AUX_W must be at least 1");
   end

   always_comb begin
      dec = '{kind: K_NONE, multi: 1'b0, illegal: 1'b0, sgn: 1'b1};
      unique case (func)
         FC_MULLO: begin dec.kind = K_MULLO; dec.multi = 1'b1; end
         FC_MULHS: begin dec.kind = K_MULHS; dec.multi = 1'b1; end
         FC_MULHU: begin dec.kind = K_MULHU; dec.multi = 1'b1; dec.sgn = 1'b0; end
         FC_MAC: begin
            dec.kind  = K_MAC;
            dec.multi = 1'b1;
            dec.sgn   = ~aux[0];
         end
         FC_ACCLO: dec.kind = K_ACCLO;
         FC_ACCHI: dec.kind = K_ACCHI;
         FC_CLZ:   dec.kind = K_CLZ;
         FC_BREV:  dec.kind = K_BREV;
         FC_POPC:  dec.kind = K_POPC;
         default:  dec.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/cax_bitops.sv
module cax_bitops #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] clz_res,
   output logic [DATA_W-1:0] brev_res,
   output logic [DATA_W-1:0] popc_res
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [CNT_W-1:0] lead_cnt;
   logic [CNT_W-1:0] ones_cnt;

   // mirror image of the operand, one wire per bit
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign brev_res[gi] = opnd[DATA_W-1-gi];
   end

   // leading zeros: count from the top until the first set bit
   always_comb begin
      logic seen;
      seen     = 1'b0;
      lead_cnt = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (opnd[i]) begin
            seen = 1'b1;
         end else if (!seen) begin
            lead_cnt = lead_cnt + CNT_W'(1);
         end
      end
   end

   always_comb begin
      ones_cnt = '0;
      for (int i = 0; i < DATA_W; i++) begin
         ones_cnt = ones_cnt + CNT_W'(opnd[i]);
      end
   end

   assign clz_res  = DATA_W'(lead_cnt);
   assign popc_res = DATA_W'(ones_cnt);

endmodule

// File: rtl/cax_mul.sv
module cax_mul #(
   parameter int DATA_W = 32,
   parameter int LAT    = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic                  sgn,
   input  logic [DATA_W-1:0]     a,
   input  logic [DATA_W-1:0]     b,
   output logic [2*DATA_W-1:0]   prod
);

   localparam int PROD_W = 2 * DATA_W;
   localparam int FULL_W = 2 * DATA_W + 2;

   logic signed [DATA_W:0]   a_q;
   logic signed [DATA_W:0]   b_q;
   logic signed [FULL_W-1:0] full;
   logic [PROD_W-1:0]        p0;

   // operand capture: one extra bit carries the sign or a zero
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= {sgn & a[DATA_W-1], a};
         b_q <= {sgn & b[DATA_W-1], b};
      end
   end

   assign full = a_q * b_q;
   assign p0   = full[PROD_W-1:0];

   if (LAT == 2) begin : g_direct
      assign prod = p0;
   end else begin : g_piped
      localparam int NSTG = LAT - 2;
      logic [PROD_W-1:0] stg [NSTG];

      always_ff @(posedge clk) begin
         if (rst) stg[0] <= '0;
         else     stg[0] <= p0;
      end

      for (genvar gs = 1; gs < NSTG; gs++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stg[gs] <= '0;
            else     stg[gs] <= stg[gs-1];
         end
      end

      assign prod = stg[NSTG-1];
   end

endmodule

// File: rtl/cust_alu_ext.sv
module cust_alu_ext
   import cax_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int AUX_W   = 5,
   parameter int MUL_LAT = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  issue_vld,
   input  logic [CAX_FUNC_W-1:0] func_fld,
   input  logic [AUX_W-1:0]      aux_fld,
   input  logic [DATA_W-1:0]     src_a,
   input  logic [DATA_W-1:0]     src_b,
   output logic [DATA_W-1:0]     dst_res,
   output logic                  stall_req,
   output logic                  illegal_op
);

   localparam int ACC_W = 2 * DATA_W;
   localparam int CNT_W = $clog2(MUL_LAT);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MUL_LAT - 1);

   if (MUL_LAT < 2) begin : g_bad_lat
      $error("cust_alu_ext: MUL_LAT must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("cust_alu_ext: DATA_W must be at least 2");
   end

   cax_dec_t         dec;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   cax_kind_e        kind_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] prod;
   logic [ACC_W-1:0] acc_sum;
   logic [DATA_W-1:0] clz_res, brev_res, popc_res;
   logic             start;
   logic             last;
   logic             fresh;

   cax_decode #(.AUX_W(AUX_W)) i_dec (
      .func (func_fld),
      .aux  (aux_fld),
      .dec  (dec)
   );

   cax_bitops #(.DATA_W(DATA_W)) i_bits (
      .opnd     (src_a),
      .clz_res  (clz_res),
      .brev_res (brev_res),
      .popc_res (popc_res)
   );

   assign fresh = issue_vld & ~busy_q;
   assign start = fresh & dec.multi;
   assign last  = busy_q & (cnt_q == LAST_CNT);

   cax_mul #(.DATA_W(DATA_W), .LAT(MUL_LAT)) i_mul (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .sgn  (dec.sgn),
      .a    (src_a),
      .b    (src_b),
      .prod (prod)
   );

   // multicycle sequencing: counter runs 1 .. MUL_LAT-1 while busy
   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= K_NONE;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(1);
         kind_q <= dec.kind;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign acc_sum = acc_q + prod;

   always_ff @(posedge clk) begin
      if (rst)                        acc_q <= '0;
      else if (last && kind_q == K_MAC) acc_q <= acc_sum;
   end

   assign stall_req  = start | (busy_q & ~last);
   assign illegal_op = fresh & dec.illegal;

   always_comb begin
      dst_res = '0;
      if (last) begin
         unique case (kind_q)
            K_MULLO:         dst_res = prod[DATA_W-1:0];
            K_MULHS, K_MULHU: dst_res = prod[ACC_W-1:DATA_W];
            K_MAC:           dst_res = acc_sum[DATA_W-1:0];
            default:         dst_res = '0;
         endcase
      end else if (fresh && !dec.multi) begin
         unique case (dec.kind)
            K_ACCLO: dst_res = acc_q[DATA_W-1:0];
            K_ACCHI: dst_res = acc_q[ACC_W-1:DATA_W];
            K_CLZ:   dst_res = clz_res;
            K_BREV:  dst_res = brev_res;
            K_POPC:  dst_res = popc_res;
            default: dst_res = '0;
         endcase
      end
   end

endmodule

// File: rtl/cax_chk.sv
module cax_chk
   import cax_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int MUL_LAT = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  issue_vld,
   input logic [CAX_FUNC_W-1:0] func_fld,
   input logic [DATA_W-1:0]     dst_res,
   input logic                  stall_req,
   input logic                  illegal_op,
   input logic [2*DATA_W-1:0]   acc_q
);

   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (rst)            run_q <= 0;
      else if (stall_req) run_q <= run_q + 1;
      else                run_q <= 0;
   end

   // R5: no stall run longer than MUL_LAT-1 cycles
   p_stall_len_r5: assert property (@(posedge clk) disable iff (rst)
      stall_req |-> (run_q < MUL_LAT - 1));

   // R8: the illegal flag comes with a zero result and no stall
   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      illegal_op |-> (dst_res == '0 && !stall_req));

   // R1: a fresh single-cycle bit operation never stalls
   p_bitop_nostall_r1: assert property (@(posedge clk) disable iff (rst)
      (issue_vld && !$past(stall_req) &&
       (func_fld == FC_CLZ || func_fld == FC_BREV || func_fld == FC_POPC))
      |-> !stall_req);

   // R9: outputs are idle without an issued instruction
   p_idle_outputs_r9: assert property (@(posedge clk) disable iff (rst)
      !issue_vld |-> (!stall_req && !illegal_op && dst_res == '0));

   // R10: the accumulator is zero right after reset
   p_acc_clear_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (acc_q == '0));

endmodule

bind cust_alu_ext cax_chk #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) i_chk (
   .clk        (clk),
   .rst        (rst),
   .issue_vld  (issue_vld),
   .func_fld   (func_fld),
   .dst_res    (dst_res),
   .stall_req  (stall_req),
   .illegal_op (illegal_op),
   .acc_q      (acc_q)
);

// File: tb/test_cust_alu_ext.sv
module test_cust_alu_ext;

   localparam int LAT = 4;
   localparam logic [5:0] F_MULLO = 6'h10, F_MULHS = 6'h11, F_MULHU = 6'h12,
                          F_MAC = 6'h13, F_ACCLO = 6'h14, F_ACCHI = 6'h15,
                          F_CLZ = 6'h20, F_BREV = 6'h21, F_POPC = 6'h22;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue_vld = 1'b0;
   logic [5:0]  func_fld = '0;
   logic [4:0]  aux_fld = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [31:0] dst_res;
   logic        stall_req, illegal_op;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [63:0] acc_m = '0;

   always #5 clk = ~clk;

   cust_alu_ext #(.DATA_W(32), .AUX_W(5), .MUL_LAT(LAT)) i_cust_alu_ext (
      .clk(clk), .rst(rst), .issue_vld(issue_vld), .func_fld(func_fld),
      .aux_fld(aux_fld), .src_a(src_a), .src_b(src_b), .dst_res(dst_res),
      .stall_req(stall_req), .illegal_op(illegal_op)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic bit is_legal(input logic [5:0] f);
      return f inside {F_MULLO, F_MULHS, F_MULHU, F_MAC, F_ACCLO, F_ACCHI,
                       F_CLZ, F_BREV, F_POPC};
   endfunction

   function automatic bit is_multi(input logic [5:0] f);
      return f inside {F_MULLO, F_MULHS, F_MULHU, F_MAC};
   endfunction

   function automatic logic [63:0] mprod(input logic [5:0] f, input logic [4:0] x,
                                         input logic [31:0] a, input logic [31:0] b);
      bit s;
      s = (f == F_MULHU) ? 1'b0 : (f == F_MAC) ? ~x[0] : 1'b1;
      if (s) return longint'($signed(a)) * longint'($signed(b));
      return {32'b0, a} * {32'b0, b};
   endfunction

   function automatic logic [31:0] m_clz(input logic [31:0] a);
      for (int i = 31; i >= 0; i--) if (a[i]) return 32'(31 - i);
      return 32;
   endfunction

   function automatic logic [31:0] m_brev(input logic [31:0] a);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = a[i];
      return r;
   endfunction

   function automatic string tag_of(input logic [5:0] f);
      case (f)
         F_MULLO, F_MULHS, F_MULHU: return "R6";
         F_MAC, F_ACCLO, F_ACCHI:   return "R7";
         F_CLZ:  return "R2";
         F_BREV: return "R3";
         F_POPC: return "R4";
         default: return "R8";
      endcase
   endfunction

   // issue one instruction, hold it through any stall, sample before each edge
   task automatic run_op(input logic [5:0] f, input logic [4:0] x,
                         input logic [31:0] a, input logic [31:0] b, input bit scr,
                         output logic [31:0] r, output int st, output bit il);
      @(negedge clk);
      issue_vld = 1'b1; func_fld = f; aux_fld = x; src_a = a; src_b = b;
      #4;
      st = 0;
      while (stall_req === 1'b1 && st < 16) begin
         st++;
         @(negedge clk);
         if (scr) begin src_a = $urandom; src_b = $urandom; end
         #4;
      end
      r  = dst_res;
      il = illegal_op;
      @(posedge clk);
      #1 issue_vld = 1'b0;
   endtask

   task automatic check_op(input logic [5:0] f, input logic [4:0] x,
                           input logic [31:0] a, input logic [31:0] b, input bit scr,
                           input string tag);
      logic [31:0] r, exp;
      logic [63:0] p;
      int st;
      bit il;
      p = mprod(f, x, a, b);
      case (f)
         F_MULLO:          exp = p[31:0];
         F_MULHS, F_MULHU: exp = p[63:32];
         F_MAC:            exp = 32'(acc_m + p);
         F_ACCLO:          exp = acc_m[31:0];
         F_ACCHI:          exp = acc_m[63:32];
         F_CLZ:            exp = m_clz(a);
         F_BREV:           exp = m_brev(a);
         F_POPC:           exp = 32'($countones(a));
         default:          exp = '0;
      endcase
      run_op(f, x, a, b, scr, r, st, il);
      chk(r === exp, $sformatf("%s rd func=%h", tag, f), 64'(r), 64'(exp));
      chk(st == (is_multi(f) ? LAT - 1 : 0),
          $sformatf("%s stall cycles func=%h", is_multi(f) ? "R5" : "R1", f),
          64'(st), 64'(is_multi(f) ? LAT - 1 : 0));
      chk(il == !is_legal(f), $sformatf("R8 illegal flag func=%h", f),
          64'(il), 64'(!is_legal(f)));
      if (f == F_MAC) acc_m = acc_m + p;
   endtask

   function automatic logic [31:0] pick_opnd();
      case ($urandom % 6)
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h1;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R5 act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [5:0] legal [9];
      void'($urandom(32'd20251));
      legal = '{F_MULLO, F_MULHS, F_MULHU, F_MAC, F_ACCLO, F_ACCHI,
                F_CLZ, F_BREV, F_POPC};

      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      #4;
      // R9 / R10: reset state with no issue
      chk(stall_req === 1'b0, "R10 stall after reset", 64'(stall_req), 0);
      chk(dst_res === '0, "R9 rd idle after reset", 64'(dst_res), 0);
      chk(illegal_op === 1'b0, "R9 illegal idle", 64'(illegal_op), 0);
      check_op(F_ACCLO, 0, 0, 0, 0, "R10");
      check_op(F_ACCHI, 0, 0, 0, 0, "R10");

      // R9: stimulus with strobe low is ignored
      @(negedge clk);
      func_fld = F_MULLO; src_a = 32'h1234_5678; src_b = 32'h9; issue_vld = 1'b0;
      #4;
      chk(stall_req === 1'b0 && dst_res === '0, "R9 no strobe",
          {31'b0, stall_req, dst_res}, 0);

      // R2 / R3 / R4 corners
      check_op(F_CLZ, 0, 32'h0, 0, 0, "R2");
      check_op(F_CLZ, 0, 32'h1, 0, 0, "R2");
      check_op(F_CLZ, 0, 32'h8000_0000, 0, 0, "R2");
      check_op(F_BREV, 0, 32'h0000_0001, 0, 0, "R3");
      check_op(F_BREV, 0, 32'hF0F0_1234, 0, 0, "R3");
      check_op(F_POPC, 0, 32'hFFFF_FFFF, 0, 0, "R4");
      check_op(F_POPC, 0, 32'h0, 0, 0, "R4");

      // R6 sign corners
      check_op(F_MULLO, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R6");
      check_op(F_MULHS, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R6");
      check_op(F_MULHU, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R6");
      check_op(F_MULHS, 0, 32'h8000_0000, 32'h2, 0, "R6");
      check_op(F_MULHU, 0, 32'h8000_0000, 32'h2, 0, "R6");

      // R7 signed and unsigned accumulation, then reads
      check_op(F_MAC, 5'h0, 32'hFFFF_FFFF, 32'h5, 0, "R7");
      check_op(F_ACCHI, 0, 0, 0, 0, "R7");
      check_op(F_MAC, 5'h1, 32'hFFFF_FFFF, 32'h1, 0, "R7");
      check_op(F_ACCLO, 0, 0, 0, 0, "R7");
      check_op(F_ACCHI, 0, 0, 0, 0, "R7");

      // R8 undefined codes leave the accumulator alone
      check_op(6'h00, 0, 32'h5, 32'h6, 0, "R8");
      check_op(6'h3F, 0, 32'h5, 32'h6, 0, "R8");
      check_op(F_ACCLO, 0, 0, 0, 0, "R8");

      // R9 operands scrambled during stall cycles
      check_op(F_MULLO, 0, 32'h0001_0003, 32'h0000_0007, 1, "R9");
      check_op(F_MAC, 0, 32'h7FFF_FFFF, 32'h3, 1, "R9");

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [5:0] f;
         if ($urandom % 10 == 0) begin
            f = 6'($urandom);
            if (is_legal(f)) f = 6'h3E;
         end else begin
            f = legal[$urandom % 9];
         end
         check_op(f, 5'($urandom), pick_opnd(), pick_opnd(), bit'($urandom % 4 == 0),
                  tag_of(f));
      end

      // R10: reset in the middle of a multiply-accumulate
      check_op(F_MAC, 0, 32'h1234, 32'h5678, 0, "R7");
      @(negedge clk);
      issue_vld = 1'b1; func_fld = F_MAC; aux_fld = 0; src_a = 32'h99; src_b = 32'h77;
      #4;
      chk(stall_req === 1'b1, "R5 stall at issue", 64'(stall_req), 1);
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      issue_vld = 1'b0;
      #4;
      chk(stall_req === 1'b0, "R10 stall dropped by reset", 64'(stall_req), 0);
      acc_m = '0;
      check_op(F_ACCLO, 0, 0, 0, 0, "R10");
      check_op(F_ACCHI, 0, 0, 0, 0, "R10");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule